// File: doc/BRIEF.md
# Random Backpressure Congestion Injector

This block sits in series with one flow-control signal of a design under test, such as a full flag, a busy flag or the ready of a ready/valid handshake. The true signal goes in and a modified copy comes out. At random moments the block makes the copy report congestion that the real logic does not have. Real congestion always passes through, so transfers are neither lost nor duplicated. The only effect is extra backpressure that stirs activity which a fixed test would otherwise leave untouched.

A 16-bit shift-register generator, seeded per instance, is sampled once per countdown window. The sample is compared against a probability threshold, and the result holds congestion on or off for the whole next window. A parameter selects the polarity. In the busy/full style, congestion is added by OR. In the ready style, ready is masked off. A global enable returns the block to pure passthrough. Instances carry their own seed, period and threshold, so any number of them can be placed side by side. A saturating counter records how many cycles the output differed from the input.

Top module: `bp_congestor`

## Requirements
- R1: With ACTIVE_LOW=0, sig_out = sig_in | (en & cong), where cong is the internal congestion state. A high sig_in always gives a high sig_out.
- R2: With ACTIVE_LOW=1, sig_out = sig_in & ~(en & cong). A low sig_in always gives a low sig_out.
- R3: While en is low, sig_out equals sig_in. The generator, countdown and congestion state keep running.
- R4: In each cycle with rst_n low, the generator loads seed. A seed of zero is replaced by DEFAULT_SEED (16'hACE1). Every later cycle it steps to {g[14:0], g[15]^g[14]^g[12]^g[3]}.
- R5: Reset clears cong and loads the countdown with period. After reset, a nonzero countdown decrements. In a cycle where the countdown is zero, it reloads with period and cong takes (g < thresh), using the generator value of that cycle. Between these events cong holds.
- R6: With thresh = 0, congestion is never injected, so sig_out equals sig_in.
- R7: accept marks a completed transfer. It is up_valid & sig_out with ACTIVE_LOW=1, and up_valid & ~sig_out with ACTIVE_LOW=0.
- R8: diff_cnt is cleared by reset. It increments by one after each cycle in which sig_out differs from sig_in, and it saturates at all ones.
- R9: Instances with different seeds, periods and thresholds follow their own sequences independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global injection enable |
| seed | input | 16 | Generator seed, loaded during reset |
| period | input | PW | Countdown reload value (window is period+1 cycles) |
| thresh | input | 16 | Probability threshold; congest when sample < thresh |
| sig_in | input | 1 | True flow-control signal |
| sig_out | output | 1 | Modified flow-control signal |
| up_valid | input | 1 | Upstream valid, for transfer marking |
| accept | output | 1 | A transfer completes this cycle |
| diff_cnt | output | CW | Saturating count of cycles where sig_out differed from sig_in |

## Verification
The bench builds two instances side by side. One uses ACTIVE_LOW=0 with an 8-bit period and a 4-bit difference counter, so the counter saturates within a few dozen cycles. The other uses ACTIVE_LOW=1 with a 16-bit counter that never saturates in the run. Short periods of 3 to 5 cycles put many window boundaries and threshold decisions into each phase. A zero seed on the first instance exercises the substitute seed. Zero and random thresholds, together with a toggling enable, cover the passthrough and injection cases in both polarities.

// File: rtl/bp_congestor.sv
module bp_congestor #(
  parameter bit          ACTIVE_LOW   = 1'b0,
  parameter int          PW           = 16,
  parameter int          CW           = 16,
  parameter logic [15:0] DEFAULT_SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [15:0]   seed,
  input  logic [PW-1:0] period,
  input  logic [15:0]   thresh,
  input  logic          sig_in,
  output logic          sig_out,
  input  logic          up_valid,
  output logic          accept,
  output logic [CW-1:0] diff_cnt
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [15:0]   gen_q;
  logic [PW-1:0] cnt_q;
  logic          cong_q;

  wire        inject   = en & cong_q;
  wire [15:0] seed_fix = (seed == 16'h0) ? DEFAULT_SEED : seed;
  wire        gen_fb   = gen_q[15] ^ gen_q[14] ^ gen_q[12] ^ gen_q[3];

  generate
    if (ACTIVE_LOW) begin : g_ready
      assign sig_out = sig_in & ~inject;
      assign accept  = up_valid & sig_out;
    end else begin : g_busy
      assign sig_out = sig_in | inject;
      assign accept  = up_valid & ~sig_out;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_q  <= seed_fix;
      cnt_q  <= period;
      cong_q <= 1'b0;
    end else begin
      gen_q <= {gen_q[14:0], gen_fb};
      if (cnt_q == '0) begin
        cnt_q  <= period;
        cong_q <= (gen_q < thresh);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      diff_cnt <= '0;
    else if ((sig_out != sig_in) && (diff_cnt != CMAX))
      diff_cnt <= diff_cnt + 1'b1;
  end
endmodule

module bp_congestor_chk #(
  parameter bit ACTIVE_LOW = 1'b0,
  parameter int PW         = 16,
  parameter int CW         = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          sig_in,
  input logic          sig_out,
  input logic          up_valid,
  input logic          accept,
  input logic [CW-1:0] diff_cnt,
  input logic [PW-1:0] cnt_q,
  input logic          cong_q
);
  a_r1_real_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ACTIVE_LOW && sig_in) |-> sig_out);
  a_r2_real_idle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ACTIVE_LOW && !sig_in) |-> !sig_out);
  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sig_out == sig_in));
  a_r5_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(cong_q));
  a_r7_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> up_valid);
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_out != sig_in) && (diff_cnt != {CW{1'b1}})) |=> (diff_cnt == $past(diff_cnt) + 1'b1));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_out == sig_in) |=> $stable(diff_cnt));
endmodule

bind bp_congestor bp_congestor_chk #(.ACTIVE_LOW(ACTIVE_LOW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sig_in(sig_in), .sig_out(sig_out),
  .up_valid(up_valid), .accept(accept), .diff_cnt(diff_cnt),
  .cnt_q(cnt_q), .cong_q(cong_q)
);

// File: tb/test_bp_congestor.sv
module test_bp_congestor;
  localparam int PW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [15:0]   seed   [2];
  logic [PW-1:0] period [2];
  logic [15:0]   thresh [2];
  logic          sin    [2];
  logic          vld    [2];
  logic sout_a, sout_b, acc_a, acc_b;
  logic [3:0]  dc_a;
  logic [15:0] dc_b;

  int checks = 0, fails = 0;
  string tag = "R4";

  always #10 clk = ~clk;

  bp_congestor #(.ACTIVE_LOW(1'b0), .PW(PW), .CW(4)) i_bp_congestor (
    .clk(clk), .rst_n(rst_n), .en(en), .seed(seed[0]), .period(period[0]),
    .thresh(thresh[0]), .sig_in(sin[0]), .sig_out(sout_a), .up_valid(vld[0]),
    .accept(acc_a), .diff_cnt(dc_a));

  bp_congestor #(.ACTIVE_LOW(1'b1), .PW(PW), .CW(16)) i_bp_congestor_rdy (
    .clk(clk), .rst_n(rst_n), .en(en), .seed(seed[1]), .period(period[1]),
    .thresh(thresh[1]), .sig_in(sin[1]), .sig_out(sout_b), .up_valid(vld[1]),
    .accept(acc_b), .diff_cnt(dc_b));

  logic [15:0] mg [2];
  int          mc [2];
  bit          mcong [2];
  int          md [2];
  int          mmax [2] = '{15, 65535};

  function automatic logic [15:0] gen_next(input logic [15:0] g);
    return {g[14:0], g[15] ^ g[14] ^ g[12] ^ g[3]};
  endfunction

  function automatic bit exp_out(input int i);
    bit inj = en && mcong[i];
    return (i == 0) ? (sin[i] || inj) : (sin[i] && !inj);
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        mg[i] = (seed[i] == 16'h0) ? 16'hACE1 : seed[i];
        mc[i] = int'(period[i]);
        mcong[i] = 1'b0;
        md[i] = 0;
      end else begin
        if ((exp_out(i) != sin[i]) && md[i] != mmax[i]) md[i]++;
        if (mc[i] == 0) begin
          mcong[i] = (mg[i] < thresh[i]);
          mc[i] = int'(period[i]);
        end else mc[i]--;
        mg[i] = gen_next(mg[i]);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ea, eb;
    ea = exp_out(0);
    eb = exp_out(1);
    chk({tag, " R1 out busy"}, int'(sout_a), int'(ea));
    chk({tag, " R2 R9 out ready"}, int'(sout_b), int'(eb));
    chk({tag, " R7 accept busy"}, int'(acc_a), int'(vld[0] && !ea));
    chk({tag, " R7 accept ready"}, int'(acc_b), int'(vld[1] && eb));
    chk({tag, " R8 diff busy"}, int'(dc_a), md[0]);
    chk({tag, " R8 diff ready"}, int'(dc_b), md[1]);
  endtask

  task automatic randomize_ins(input bit rnd_en);
    for (int i = 0; i < 2; i++) begin
      sin[i] = 1'($urandom);
      vld[i] = 1'($urandom);
    end
    if (rnd_en) en = 1'($urandom);
  endtask

  task automatic do_reset(input logic [15:0] s0, input logic [15:0] s1);
    @(negedge clk);
    rst_n = 1'b0;
    seed[0] = s0;
    seed[1] = s1;
    repeat (2) @(negedge clk);
    tag = "R8 reset";
    check_all();
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input bit rnd_en, input bit rnd_per);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
      randomize_ins(rnd_en);
      if (rnd_per && ($urandom % 50 == 0)) begin
        period[0] = PW'($urandom % 7);
        period[1] = PW'($urandom % 7);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      sin[i] = 1'b0; vld[i] = 1'b0; thresh[i] = 16'h8000;
    end
    period[0] = 8'd3;
    period[1] = 8'd5;
    en = 1'b1;
    do_reset(16'h0000, 16'h1234);
    tag = "R4 R5 R9";
    run(1500, 1'b0, 1'b0);
    tag = "R3";
    run(1000, 1'b1, 1'b0);
    thresh[0] = 16'h0000;
    thresh[1] = 16'h0000;
    en = 1'b1;
    do_reset(16'hBEEF, 16'h0F0F);
    tag = "R6";
    run(500, 1'b0, 1'b0);
    thresh[0] = 16'hFFFF;
    thresh[1] = 16'($urandom);
    do_reset(16'($urandom) | 16'h1, 16'($urandom) | 16'h2);
    tag = "R5";
    run(2000, 1'b0, 1'b1);
    thresh[0] = 16'($urandom);
    thresh[1] = 16'hFFFF;
    tag = "R5 R3";
    run(1000, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule